// File: doc/BRIEF.md
# MII Management Register Front-End

This block sits between a host register bus and a modelled Ethernet PHY. The host writes a small bank of management registers. One register holds the target PHY register address, one holds a command word whose bit 0 requests a read, and one holds the data to be written. A rising request bit reads the modelled PHY register and places the 16-bit answer in a result register. Any write of the data register immediately writes the modelled PHY.

The modelled PHY keeps a local basic-control word and a local basic-status word. The link bit of the status word tracks an external link input. The remaining host registers follow a per-index access policy: read-write, write-only, write-1-to-clear (with an event input that raises bits) or read-only. The policy and the register indices are parameters.

Top module: `mii_mgmt_regfile`

## Requirements
- R1: A host write to the command register (index 0) whose data has bit 0 set, while the stored bit 0 is 0, loads the result register (index 3) with the PHY register selected by bits 4:0 of the address register (index 1). The value is readable from the next clock on.
- R2: A command write while the stored bit 0 is already 1 leaves the result register unchanged. The command register always stores the full written word.
- R3: Reading PHY register 0 returns the local control copy. Reading PHY register 1 returns the local status copy.
- R4: Reading PHY register 10 returns 16'h3000, that is, bits 13 and 12 set. Any other PHY register address returns 0.
- R5: A host write to the data register (index 2) stores only the low 16 bits. When the address register selects PHY register 0, it also stores that value into the control copy with bits 15 and 8 cleared.
- R6: A data-register write while any PHY register other than 0 is selected leaves the control copy unchanged.
- R7: Bit 2 of the status copy equals the link input of the previous clock. All other status bits stay 0.
- R8: Read-write registers (index 1 and index 4) store and return the full 32-bit written word.
- R9: In the write-1-to-clear register (index 5), bits written as 1 clear. Bits set on the event input are raised, and a set wins over a clear in the same cycle.
- R10: The write-only register (index 6) reads as 0. Host writes to the read-only register (index 7) and to the result register have no visible effect.
- R11: A synchronous reset clears every host register, the result register and both PHY copies to 0.
- R12: Bits 12:8 of the address register (the PHY address) do not change the result of a read or a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | 3 | Host write register index |
| wr_data | input | 32 | Host write data |
| rd_idx | input | 3 | Host read register index |
| rd_data | output | 32 | Host read data (combinational) |
| link_up | input | 1 | Link state of the attached PHY, 1 means up |
| flag_set | input | 32 | Event bits raised into write-1-to-clear registers |

## Verification
Every host register write, read result and PHY control update is visible on `rd_data` one clock after the write strobe. The link bit lags `link_up` by one clock, so a read cycle sees the link sampled at the edge before it. The bench drives inputs on the falling edge and runs a reference model at each rising edge. It compares `rd_data` late in the low phase of every clock, and adds targeted checks that sample one full clock after each stimulus.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

   // host register access policies
   localparam logic [2:0] ACC_RW   = 3'd0;
   localparam logic [2:0] ACC_WO   = 3'd1;
   localparam logic [2:0] ACC_W1C  = 3'd2;
   localparam logic [2:0] ACC_RO   = 3'd3;
   localparam logic [2:0] ACC_RW16 = 3'd4;  // low half stored only
   localparam logic [2:0] ACC_EXT  = 3'd5;  // value held outside the bank

   // modelled PHY register indices and bit positions
   localparam logic [4:0] PHY_BCTL  = 5'd0;
   localparam logic [4:0] PHY_BSTAT = 5'd1;
   localparam logic [4:0] PHY_GSTAT = 5'd10;
   localparam int BCTL_RESET_BIT  = 15;
   localparam int BCTL_DUPLEX_BIT = 8;
   localparam int BSTAT_LINK_BIT  = 2;
   localparam int GSTAT_LOCAL_OK  = 13;
   localparam int GSTAT_REMOTE_OK = 12;

endpackage

// File: rtl/mii_mgmt_bank.sv
module mii_mgmt_bank
   import mii_mgmt_pkg::*;
#(
   parameter int DW = 32,
   parameter int NREG = 8,
   parameter int IW = $clog2(NREG),
   parameter logic [3*NREG-1:0] ACC_MAP = '0,
   parameter int CMD_IDX = 0,
   parameter int ADDR_IDX = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [DW-1:0] flag_set,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_val,
   output logic [DW-1:0] cmd_val,
   output logic [DW-1:0] addr_val
);

   localparam int HALF = 16;

   logic [DW-1:0] q    [NREG];
   logic [DW-1:0] view [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [2:0] ACC = ACC_MAP[3*i +: 3];
      logic hit;
      assign hit = wr_en && (wr_idx == IW'(i));

      if (ACC == ACC_RW || ACC == ACC_WO) begin : g_full
         always_ff @(posedge clk) begin
            if (rst)      q[i] <= '0;
            else if (hit) q[i] <= wr_data;
         end
      end else if (ACC == ACC_RW16) begin : g_half
         always_ff @(posedge clk) begin
            if (rst)      q[i] <= '0;
            else if (hit) q[i] <= {{(DW-HALF){1'b0}}, wr_data[HALF-1:0]};
         end
      end else if (ACC == ACC_W1C) begin : g_w1c
         logic [DW-1:0] clr;
         assign clr = hit ? wr_data : '0;
         always_ff @(posedge clk) begin
            if (rst) q[i] <= '0;
            else     q[i] <= (q[i] & ~clr) | flag_set;
         end
      end else begin : g_none
         assign q[i] = '0;
      end

      if (ACC == ACC_WO || ACC == ACC_EXT) begin : g_hide
         assign view[i] = '0;
      end else begin : g_show
         assign view[i] = q[i];
      end
   end

   assign rd_val   = view[rd_idx];
   assign cmd_val  = q[CMD_IDX];
   assign addr_val = q[ADDR_IDX];

endmodule

// File: rtl/mii_phy_model.sv
module mii_phy_model
   import mii_mgmt_pkg::*;
#(
   parameter int RW = 5,
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          link_up,
   input  logic          wr_fire,
   input  logic [RW-1:0] wr_reg,
   input  logic [PW-1:0] wr_val,
   input  logic [RW-1:0] rd_reg,
   output logic [PW-1:0] rd_val,
   output logic [PW-1:0] ctrl_copy,
   output logic [PW-1:0] stat_copy
);

   localparam logic [PW-1:0] STRIP =
      PW'((1 << BCTL_RESET_BIT) | (1 << BCTL_DUPLEX_BIT));
   localparam logic [PW-1:0] GSTAT_VAL =
      PW'((1 << GSTAT_LOCAL_OK) | (1 << GSTAT_REMOTE_OK));

   logic link_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_copy <= '0;
         link_q    <= 1'b0;
      end else begin
         link_q <= link_up;
         if (wr_fire && wr_reg == RW'(PHY_BCTL))
            ctrl_copy <= wr_val & ~STRIP;
      end
   end

   always_comb begin
      stat_copy = '0;
      stat_copy[BSTAT_LINK_BIT] = link_q;
   end

   always_comb begin
      case (rd_reg)
         RW'(PHY_BCTL):  rd_val = ctrl_copy;
         RW'(PHY_BSTAT): rd_val = stat_copy;
         RW'(PHY_GSTAT): rd_val = GSTAT_VAL;
         default:        rd_val = '0;
      endcase
   end

endmodule

// File: rtl/mii_mgmt_regfile.sv
module mii_mgmt_regfile
   import mii_mgmt_pkg::*;
#(
   parameter int DW = 32,
   parameter int NREG = 8,
   parameter int IW = $clog2(NREG),
   parameter logic [3*NREG-1:0] ACC_MAP =
      {ACC_RO, ACC_WO, ACC_W1C, ACC_RW, ACC_EXT, ACC_RW16, ACC_RW, ACC_RW},
   parameter int CMD_IDX = 0,
   parameter int ADDR_IDX = 1,
   parameter int CTRL_IDX = 2,
   parameter int STAT_IDX = 3,
   parameter int READ_BIT = 0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data,
   input  logic          link_up,
   input  logic [DW-1:0] flag_set
);

   localparam int PW = 16;
   localparam int RAW = 5;

   if (DW < PW) begin : g_bad_width
      $error("data width must hold a 16-bit PHY word");
   end
   if (CMD_IDX >= NREG || ADDR_IDX >= NREG || CTRL_IDX >= NREG || STAT_IDX >= NREG) begin : g_bad_idx
      $error("special register index out of range");
   end
   if (ACC_MAP[3*CTRL_IDX +: 3] != ACC_RW16 || ACC_MAP[3*STAT_IDX +: 3] != ACC_EXT) begin : g_bad_map
      $error("access map must mark data and result registers");
   end
   if (READ_BIT >= DW) begin : g_bad_bit
      $error("read request bit outside data width");
   end

   logic [DW-1:0]  bank_rd, cmd_q, addr_q;
   logic [PW-1:0]  phy_rd, phy_ctrl, phy_stat, stat_q;
   logic           read_fire, ctrl_fire;
   logic [RAW-1:0] phy_reg;

   mii_mgmt_bank #(
      .DW(DW), .NREG(NREG), .IW(IW), .ACC_MAP(ACC_MAP),
      .CMD_IDX(CMD_IDX), .ADDR_IDX(ADDR_IDX)
   ) u_bank (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .flag_set(flag_set), .rd_idx(rd_idx),
      .rd_val(bank_rd), .cmd_val(cmd_q), .addr_val(addr_q)
   );

   assign phy_reg   = addr_q[RAW-1:0];
   assign read_fire = wr_en && (wr_idx == IW'(CMD_IDX))
                      && !cmd_q[READ_BIT] && wr_data[READ_BIT];
   assign ctrl_fire = wr_en && (wr_idx == IW'(CTRL_IDX));

   mii_phy_model #(.RW(RAW), .PW(PW)) u_phy (
      .clk(clk), .rst(rst), .link_up(link_up),
      .wr_fire(ctrl_fire), .wr_reg(phy_reg), .wr_val(wr_data[PW-1:0]),
      .rd_reg(phy_reg), .rd_val(phy_rd),
      .ctrl_copy(phy_ctrl), .stat_copy(phy_stat)
   );

   always_ff @(posedge clk) begin
      if (rst)            stat_q <= '0;
      else if (read_fire) stat_q <= phy_rd;
   end

   assign rd_data = (rd_idx == IW'(STAT_IDX)) ? {{(DW-PW){1'b0}}, stat_q} : bank_rd;

endmodule

// File: rtl/mii_mgmt_checks.sv
module mii_mgmt_checks #(
   parameter int DW = 32,
   parameter int IW = 3,
   parameter int CMD_IDX = 0,
   parameter int CTRL_IDX = 2,
   parameter int READ_BIT = 0
) (
   input logic          clk,
   input logic          rst,
   input logic          wr_en,
   input logic [IW-1:0] wr_idx,
   input logic [DW-1:0] wr_data,
   input logic          link_up,
   input logic [DW-1:0] cmd_q,
   input logic [DW-1:0] addr_q,
   input logic [15:0]   stat_q,
   input logic [15:0]   phy_ctrl,
   input logic [15:0]   phy_stat
);

   logic cmd_wr, ctrl_wr;
   assign cmd_wr  = wr_en && (wr_idx == IW'(CMD_IDX));
   assign ctrl_wr = wr_en && (wr_idx == IW'(CTRL_IDX));

   a_r2_no_refire: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && cmd_q[READ_BIT]) |=> $stable(stat_q));

   a_r10_result_held: assert property (@(posedge clk) disable iff (rst)
      !cmd_wr |=> $stable(stat_q));

   a_r4_gbit_status: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && !cmd_q[READ_BIT] && wr_data[READ_BIT] && addr_q[4:0] == 5'd10)
      |=> stat_q == 16'h3000);

   a_r5_ctrl_stripped: assert property (@(posedge clk) disable iff (rst)
      (phy_ctrl[15] == 1'b0) && (phy_ctrl[8] == 1'b0));

   a_r6_ctrl_kept: assert property (@(posedge clk) disable iff (rst)
      !(ctrl_wr && addr_q[4:0] == 5'd0) |=> $stable(phy_ctrl));

   a_r7_link_tracks: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> phy_stat[2] == $past(link_up));

endmodule

bind mii_mgmt_regfile mii_mgmt_checks #(
   .DW(DW), .IW(IW), .CMD_IDX(CMD_IDX), .CTRL_IDX(CTRL_IDX), .READ_BIT(READ_BIT)
) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
   .link_up(link_up), .cmd_q(cmd_q), .addr_q(addr_q), .stat_q(stat_q),
   .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
);

// File: tb/mii_mgmt_regfile_test.sv
module mii_mgmt_regfile_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_idx = '0;
   logic [31:0] rd_data;
   logic        link_up = 1'b0;
   logic [31:0] flag_set = '0;

   int errors = 0;
   int checks = 0;
   bit model_on = 1'b0;

   always #5 clk = ~clk;

   mii_mgmt_regfile uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .link_up(link_up), .flag_set(flag_set)
   );

   // behavioural reference
   logic [31:0] m_reg [8];
   logic [15:0] m_stat, m_pctl;
   logic        m_link;

   function automatic logic [15:0] phy_answer(input logic [4:0] a);
      case (a)
         5'd0:    return m_pctl;
         5'd1:    return {13'd0, m_link, 2'b00};
         5'd10:   return 16'h3000;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic logic [31:0] m_read(input logic [2:0] i);
      case (i)
         3'd3:    return {16'd0, m_stat};
         3'd6, 3'd7: return 32'd0;
         default: return m_reg[i];
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 8; i++) m_reg[i] = '0;
         m_stat = '0; m_pctl = '0; m_link = 1'b0;
      end else begin
         logic [15:0] ans;
         ans = phy_answer(m_reg[1][4:0]);
         if (wr_en) begin
            case (wr_idx)
               3'd0: begin
                  if (!m_reg[0][0] && wr_data[0]) m_stat = ans;
                  m_reg[0] = wr_data;
               end
               3'd2: begin
                  m_reg[2] = {16'd0, wr_data[15:0]};
                  if (m_reg[1][4:0] == 5'd0) m_pctl = wr_data[15:0] & 16'h7EFF;
               end
               3'd5: m_reg[5] = m_reg[5] & ~wr_data;
               3'd1, 3'd4, 3'd6: m_reg[wr_idx] = wr_data;
               default: ;
            endcase
         end
         m_reg[5] = m_reg[5] | flag_set;
         m_link = link_up;
      end
   end

   function automatic string tag_of(input logic [2:0] i);
      case (i)
         3'd0, 3'd1, 3'd4: return "R8";
         3'd2: return "R5";
         3'd3: return "R1";
         3'd5: return "R9";
         default: return "R10";
      endcase
   endfunction

   always @(negedge clk) begin
      #4;
      if (model_on) begin
         checks++;
         if (rd_data !== m_read(rd_idx)) begin
            errors++;
            $display("FAIL %s model idx %0d: actual %h expected %h",
                     tag_of(rd_idx), rd_idx, rd_data, m_read(rd_idx));
         end
      end
   end

   task automatic wr(input logic [2:0] i, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = i; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic chk(input string req, input logic [2:0] i, input logic [31:0] exp);
      @(negedge clk);
      rd_idx = i;
      #2;
      checks++;
      if (rd_data !== exp) begin
         errors++;
         $display("FAIL %s idx %0d: actual %h expected %h", req, i, rd_data, exp);
      end
   endtask

   task automatic phy_read(input logic [31:0] addr);
      wr(3'd1, addr);
      wr(3'd0, 32'd0);
      wr(3'd0, 32'd1);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_on = 1'b1;
      for (int i = 0; i < 8; i++) chk("R11", 3'(i), 32'd0);

      link_up = 1'b1;
      phy_read(32'h0000_0001);
      chk("R1 R3 R7", 3'd3, 32'h0000_0004);
      chk("R2", 3'd0, 32'h0000_0001);

      link_up = 1'b0;
      repeat (2) @(negedge clk);
      wr(3'd0, 32'h0000_0003);
      chk("R2", 3'd3, 32'h0000_0004);
      chk("R2", 3'd0, 32'h0000_0003);
      phy_read(32'h0000_0001);
      chk("R7", 3'd3, 32'h0000_0000);

      wr(3'd1, 32'h0000_0000);
      wr(3'd2, 32'hFFFF_FFFF);
      chk("R5", 3'd2, 32'h0000_FFFF);
      phy_read(32'h0000_0000);
      chk("R5 R3", 3'd3, 32'h0000_7EFF);

      wr(3'd1, 32'h0000_1F05);
      wr(3'd2, 32'h0000_1234);
      chk("R5", 3'd2, 32'h0000_1234);
      phy_read(32'h0000_1F00);
      chk("R6 R12", 3'd3, 32'h0000_7EFF);
      wr(3'd1, 32'h0000_1A00);
      wr(3'd2, 32'h0000_0140);
      phy_read(32'h0000_0000);
      chk("R12", 3'd3, 32'h0000_0040);

      phy_read(32'h0000_000A);
      chk("R4", 3'd3, 32'h0000_3000);
      phy_read(32'h0000_1507);
      chk("R4", 3'd3, 32'h0000_0000);

      wr(3'd3, 32'hDEAD_BEEF);
      chk("R10", 3'd3, 32'h0000_0000);
      wr(3'd7, 32'hDEAD_BEEF);
      chk("R10", 3'd7, 32'h0000_0000);
      wr(3'd6, 32'hCAFE_F00D);
      chk("R10", 3'd6, 32'h0000_0000);

      wr(3'd4, 32'hA5A5_0F0F);
      chk("R8", 3'd4, 32'hA5A5_0F0F);
      chk("R8", 3'd1, 32'h0000_1507);

      @(negedge clk); flag_set = 32'h0000_000F;
      @(negedge clk); flag_set = 32'd0;
      chk("R9", 3'd5, 32'h0000_000F);
      wr(3'd5, 32'h0000_0005);
      chk("R9", 3'd5, 32'h0000_000A);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 3'd5; wr_data = 32'h0000_000A; flag_set = 32'h0000_0002;
      @(negedge clk);
      wr_en = 1'b0; flag_set = 32'd0;
      chk("R9", 3'd5, 32'h0000_0002);

      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      for (int i = 0; i < 8; i++) chk("R11", 3'(i), 32'd0);

      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule